// File: doc/BRIEF.md
# Multi-Context PDU Reassembler

This block sits on the receive side of a packet fabric endpoint and rebuilds protocol data units (PDUs) that a sender split into segments. Every segment belongs to a segmentation context. Segments of different contexts may arrive interleaved, but the beats of one segment arrive back to back. The block keeps one state record per context. Each record holds whether a PDU is open, how many payload bytes it has collected so far, and the class and stream values that the opening segment carried.

Payload beats are written to a fixed buffer region per context, at the byte offset they occupy within their PDU. When the closing segment's last beat arrives, the block emits one completion descriptor carrying the context, total length, class and stream. Broken sequences are reported on a separate error channel with a code and the context, and the affected PDU is dropped.

Top module: `pdu_reassembler`

## Requirements
- R1: After synchronous active-high reset, `wr_en`, `done_valid` and `err_valid` are low and every context is idle, so a continuation segment arriving first is reported as an orphan.
- R2: The segment kind is encoded as 0 = single, 1 = start, 2 = continuation, 3 = end. Beat byte counts (`in_bytes`, 1 to 4, below 4 only on a segment's final beat) add up per context. One cycle after the last beat of an end segment, `done_valid` pulses with the total length and the class and stream latched from the start segment.
- R3: A single segment opens and closes a PDU by itself. Its completion reports its own byte count, class and stream.
- R4: Contexts are independent while their segments interleave. Completions come out in the order the end segments arrive, and each carries its own context in `done_ctx`.
- R5: Each accepted beat is written one cycle later with `wr_addr` = {context, byte offset / 4} and `wr_data` equal to the input word. The offset starts at 0 for each PDU.
- R6: A continuation or end segment for an idle context raises error code 0 (orphan). Its beats are not written and the context stays idle.
- R7: A start or single segment for a context with an open PDU raises error code 1 (restart). The old PDU is abandoned, and the new one counts from zero.
- R8: A PDU may reach exactly 65536 bytes. A beat that would take it beyond that raises error code 2 (oversize) and is not written. Any further continuation beats of that PDU are dropped silently. The next end segment returns the context to idle without a completion. If the overflow happens inside an end segment, the context goes idle at once.
- R9: An end segment whose class or stream differs from the values latched at start raises error code 3 (mismatch). It produces no completion and no write, and the context goes idle.
- R10: Every error is reported one cycle after the offending beat with the segment's context in `err_ctx`. At most one error is reported per beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_first | input | 1 | First beat of a segment |
| in_last | input | 1 | Last beat of a segment |
| in_kind | input | 2 | Segment kind (0 single, 1 start, 2 continuation, 3 end) |
| in_ctx | input | CTX_W | Segmentation context |
| in_class | input | 8 | Class from the segment header |
| in_stream | input | 16 | Stream ID from the segment header |
| in_data | input | DATA_W | Payload word |
| in_bytes | input | CNT_W | Valid payload bytes in this beat |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | CTX_W+14 | Buffer word address: context region and word offset |
| wr_data | output | DATA_W | Buffer write data |
| done_valid | output | 1 | Completion descriptor valid |
| done_ctx | output | CTX_W | Context of the completed PDU |
| done_len | output | 17 | PDU length in bytes |
| done_class | output | 8 | Class of the completed PDU |
| done_stream | output | 16 | Stream of the completed PDU |
| err_valid | output | 1 | Error report valid |
| err_code | output | 2 | 0 orphan, 1 restart, 2 oversize, 3 mismatch |
| err_ctx | output | CTX_W | Context of the error |

## Verification
The bench builds the block with its defaults: four contexts and a 32-bit data word. With only four contexts, every context can be swept through every segment kind, starting both from an idle state and from an open PDU. With a four-byte word, every possible partial byte count on a final beat is covered. Because a full 64 KB PDU fits within the cycle budget at this word width, the bench drives the exact-limit case, overflow inside a continuation segment and overflow inside an end segment.

// File: rtl/pdu_reasm_pkg.sv
package pdu_reasm_pkg;

    localparam int MAX_LG  = 16;
    localparam int MAX_PDU = 1 << MAX_LG;
    localparam int LEN_W   = MAX_LG + 1;
    localparam int CLASS_W = 8;
    localparam int STRM_W  = 16;

    typedef enum logic [1:0] {
        SEG_SINGLE = 2'd0,
        SEG_START  = 2'd1,
        SEG_CONT   = 2'd2,
        SEG_END    = 2'd3
    } seg_kind_e;

    typedef enum logic [1:0] {
        ERR_ORPHAN   = 2'd0,
        ERR_RESTART  = 2'd1,
        ERR_OVERSIZE = 2'd2,
        ERR_MISMATCH = 2'd3
    } err_code_e;

    typedef enum logic [1:0] {
        CTX_IDLE    = 2'd0,
        CTX_ACTIVE  = 2'd1,
        CTX_DISCARD = 2'd2
    } ctx_state_e;

    typedef struct packed {
        ctx_state_e           st;
        logic [LEN_W-1:0]     len;
        logic [CLASS_W-1:0]   cls;
        logic [STRM_W-1:0]    strm;
    } ctx_entry_t;

    localparam ctx_entry_t CTX_RESET = '{st: CTX_IDLE, len: '0, cls: '0, strm: '0};

    function automatic logic kind_opens(input seg_kind_e k);
        return (k == SEG_START) || (k == SEG_SINGLE);
    endfunction

    function automatic logic kind_closes(input seg_kind_e k);
        return (k == SEG_END) || (k == SEG_SINGLE);
    endfunction

endpackage

// File: rtl/pdu_reasm_ctx_table.sv
module pdu_reasm_ctx_table
    import pdu_reasm_pkg::*;
#(
    parameter int NCTX  = 4,
    parameter int CTX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTX_W-1:0] rd_idx,
    output ctx_entry_t       rd_entry,
    input  logic             upd_en,
    input  logic [CTX_W-1:0] upd_idx,
    input  ctx_entry_t       upd_entry
);

    ctx_entry_t slots [NCTX];

    for (genvar g = 0; g < NCTX; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= CTX_RESET;
            end else if (upd_en && (upd_idx == CTX_W'(g))) begin
                slots[g] <= upd_entry;
            end
        end
    end

    always_comb begin
        rd_entry = CTX_RESET;
        for (int i = 0; i < NCTX; i++) begin
            if (rd_idx == CTX_W'(i)) rd_entry = slots[i];
        end
    end

endmodule

// File: rtl/pdu_reasm_engine.sv
module pdu_reasm_engine
    import pdu_reasm_pkg::*;
#(
    parameter int LANE_W  = 2,
    parameter int CNT_W   = 3,
    parameter int WADDR_W = 14
) (
    input  logic                in_valid,
    input  logic                in_first,
    input  logic                in_last,
    input  seg_kind_e           kind,
    input  logic [CLASS_W-1:0]  in_class,
    input  logic [STRM_W-1:0]   in_stream,
    input  logic [CNT_W-1:0]    in_bytes,
    input  logic                skip_q,
    input  ctx_entry_t          cur,
    output ctx_entry_t          nxt,
    output logic                upd,
    output logic                skip_d,
    output logic                wr_v,
    output logic [WADDR_W-1:0]  wr_word,
    output logic                done_v,
    output logic [LEN_W-1:0]    done_len,
    output logic                err_v,
    output err_code_e           err_c
);

    logic             take;
    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] sum;

    assign sum = base + LEN_W'(in_bytes);

    always_comb begin
        nxt      = cur;
        upd      = 1'b0;
        skip_d   = skip_q;
        wr_v     = 1'b0;
        wr_word  = '0;
        done_v   = 1'b0;
        done_len = '0;
        err_v    = 1'b0;
        err_c    = ERR_ORPHAN;
        take     = 1'b0;
        base     = cur.len;

        if (in_valid) begin
            if (in_first) begin
                skip_d = 1'b0;
                take   = 1'b1;
                unique case (kind)
                    SEG_SINGLE, SEG_START: begin
                        if (cur.st == CTX_ACTIVE) begin
                            err_v = 1'b1;
                            err_c = ERR_RESTART;
                        end
                        nxt.st   = CTX_ACTIVE;
                        nxt.len  = '0;
                        nxt.cls  = in_class;
                        nxt.strm = in_stream;
                        base     = '0;
                        upd      = 1'b1;
                    end
                    SEG_CONT: begin
                        if (cur.st != CTX_ACTIVE) begin
                            take   = 1'b0;
                            skip_d = 1'b1;
                            if (cur.st == CTX_IDLE) begin
                                err_v = 1'b1;
                                err_c = ERR_ORPHAN;
                            end
                        end
                    end
                    SEG_END: begin
                        if (cur.st == CTX_IDLE) begin
                            take   = 1'b0;
                            skip_d = 1'b1;
                            err_v  = 1'b1;
                            err_c  = ERR_ORPHAN;
                        end else if (cur.st == CTX_DISCARD) begin
                            take   = 1'b0;
                            skip_d = 1'b1;
                            nxt.st = CTX_IDLE;
                            upd    = 1'b1;
                        end else if ((cur.cls != in_class) || (cur.strm != in_stream)) begin
                            take   = 1'b0;
                            skip_d = 1'b1;
                            err_v  = 1'b1;
                            err_c  = ERR_MISMATCH;
                            nxt.st = CTX_IDLE;
                            upd    = 1'b1;
                        end
                    end
                endcase
            end else begin
                take = !skip_q;
            end

            if (take) begin
                upd = 1'b1;
                if (sum > LEN_W'(MAX_PDU)) begin
                    err_v  = 1'b1;
                    err_c  = ERR_OVERSIZE;
                    skip_d = 1'b1;
                    nxt.st = kind_closes(kind) ? CTX_IDLE : CTX_DISCARD;
                end else begin
                    wr_v    = 1'b1;
                    wr_word = base[MAX_LG-1:LANE_W];
                    nxt.len = sum;
                    if (in_last && kind_closes(kind)) begin
                        done_v   = 1'b1;
                        done_len = sum;
                        nxt.st   = CTX_IDLE;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pdu_reasm_outreg.sv
module pdu_reasm_outreg
    import pdu_reasm_pkg::*;
#(
    parameter int CTX_W  = 2,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_v,
    input  logic [ADDR_W-1:0]   wr_addr_d,
    input  logic [DATA_W-1:0]   wr_data_d,
    input  logic                done_v,
    input  logic [CTX_W-1:0]    ctx_d,
    input  logic [LEN_W-1:0]    len_d,
    input  logic [CLASS_W-1:0]  cls_d,
    input  logic [STRM_W-1:0]   strm_d,
    input  logic                err_v,
    input  err_code_e           err_c,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                done_valid,
    output logic [CTX_W-1:0]    done_ctx,
    output logic [LEN_W-1:0]    done_len,
    output logic [CLASS_W-1:0]  done_class,
    output logic [STRM_W-1:0]   done_stream,
    output logic                err_valid,
    output logic [1:0]          err_code,
    output logic [CTX_W-1:0]    err_ctx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            done_valid  <= 1'b0;
            done_ctx    <= '0;
            done_len    <= '0;
            done_class  <= '0;
            done_stream <= '0;
            err_valid   <= 1'b0;
            err_code    <= '0;
            err_ctx     <= '0;
        end else begin
            wr_en      <= wr_v;
            done_valid <= done_v;
            err_valid  <= err_v;
            if (wr_v) begin
                wr_addr <= wr_addr_d;
                wr_data <= wr_data_d;
            end
            if (done_v) begin
                done_ctx    <= ctx_d;
                done_len    <= len_d;
                done_class  <= cls_d;
                done_stream <= strm_d;
            end
            if (err_v) begin
                err_code <= err_c;
                err_ctx  <= ctx_d;
            end
        end
    end

endmodule

// File: rtl/pdu_reassembler.sv
module pdu_reassembler
    import pdu_reasm_pkg::*;
#(
    parameter int NCTX   = 4,
    parameter int DATA_W = 32,
    localparam int CTX_W   = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int LANES   = DATA_W / 8,
    localparam int LANE_W  = $clog2(LANES),
    localparam int CNT_W   = LANE_W + 1,
    localparam int WADDR_W = MAX_LG - LANE_W,
    localparam int ADDR_W  = CTX_W + WADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_first,
    input  logic                in_last,
    input  logic [1:0]          in_kind,
    input  logic [CTX_W-1:0]    in_ctx,
    input  logic [7:0]          in_class,
    input  logic [15:0]         in_stream,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [CNT_W-1:0]    in_bytes,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                done_valid,
    output logic [CTX_W-1:0]    done_ctx,
    output logic [16:0]         done_len,
    output logic [7:0]          done_class,
    output logic [15:0]         done_stream,
    output logic                err_valid,
    output logic [1:0]          err_code,
    output logic [CTX_W-1:0]    err_ctx
);

    ctx_entry_t           cur_entry;
    ctx_entry_t           nxt_entry;
    logic                 upd;
    logic                 skip_q;
    logic                 skip_d;
    logic                 wr_v;
    logic [WADDR_W-1:0]   wr_word;
    logic                 done_v;
    logic [LEN_W-1:0]     len_d;
    logic                 err_v;
    err_code_e            err_c;
    seg_kind_e            kind;

    assign kind = seg_kind_e'(in_kind);

    pdu_reasm_ctx_table #(.NCTX(NCTX), .CTX_W(CTX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (in_ctx),
        .rd_entry  (cur_entry),
        .upd_en    (upd),
        .upd_idx   (in_ctx),
        .upd_entry (nxt_entry)
    );

    pdu_reasm_engine #(.LANE_W(LANE_W), .CNT_W(CNT_W), .WADDR_W(WADDR_W)) u_engine (
        .in_valid  (in_valid),
        .in_first  (in_first),
        .in_last   (in_last),
        .kind      (kind),
        .in_class  (in_class),
        .in_stream (in_stream),
        .in_bytes  (in_bytes),
        .skip_q    (skip_q),
        .cur       (cur_entry),
        .nxt       (nxt_entry),
        .upd       (upd),
        .skip_d    (skip_d),
        .wr_v      (wr_v),
        .wr_word   (wr_word),
        .done_v    (done_v),
        .done_len  (len_d),
        .err_v     (err_v),
        .err_c     (err_c)
    );

    always_ff @(posedge clk) begin
        if (rst) skip_q <= 1'b0;
        else     skip_q <= skip_d;
    end

    pdu_reasm_outreg #(.CTX_W(CTX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .wr_v        (wr_v),
        .wr_addr_d   ({in_ctx, wr_word}),
        .wr_data_d   (in_data),
        .done_v      (done_v),
        .ctx_d       (in_ctx),
        .len_d       (len_d),
        .cls_d       (nxt_entry.cls),
        .strm_d      (nxt_entry.strm),
        .err_v       (err_v),
        .err_c       (err_c),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .done_valid  (done_valid),
        .done_ctx    (done_ctx),
        .done_len    (done_len),
        .done_class  (done_class),
        .done_stream (done_stream),
        .err_valid   (err_valid),
        .err_code    (err_code),
        .err_ctx     (err_ctx)
    );

endmodule

// File: rtl/pdu_reasm_chk.sv
module pdu_reasm_chk #(
    parameter int NCTX   = 4,
    parameter int DATA_W = 32,
    localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int LANE_W = $clog2(DATA_W / 8),
    localparam int ADDR_W = CTX_W + 16 - LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_first,
    input logic              in_last,
    input logic [1:0]        in_kind,
    input logic [CTX_W-1:0]  in_ctx,
    input logic [DATA_W-1:0] in_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              done_valid,
    input logic [CTX_W-1:0]  done_ctx,
    input logic [16:0]       done_len,
    input logic              err_valid,
    input logic [1:0]        err_code,
    input logic [CTX_W-1:0]  err_ctx
);

    AST_QUIET_WITHOUT_INPUT: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> (!wr_en && !done_valid && !err_valid)); // R1

    AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> $past(in_valid && in_last && (in_kind == 2'd0 || in_kind == 2'd3))); // R2

    AST_DONE_CTX_ECHO: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_ctx == $past(in_ctx))); // R4

    AST_WR_ECHO: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr[ADDR_W-1 -: CTX_W] == $past(in_ctx) && wr_data == $past(in_data))); // R5

    AST_ORPHAN_KIND: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_code == 2'd0) |-> ($past(in_valid && in_first && in_kind[1]) && !wr_en)); // R6

    AST_RESTART_KIND: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_code == 2'd1) |-> $past(in_valid && in_first && !in_kind[1])); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_len != 17'd0 && done_len <= 17'd65536)); // R8

    AST_OVERSIZE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_code == 2'd2) |-> (!wr_en && !done_valid)); // R8

    AST_MISMATCH_DROPS: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_code == 2'd3) |-> (!wr_en && !done_valid && $past(in_first && in_kind == 2'd3))); // R9

    AST_ERR_CTX_ECHO: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_ctx == $past(in_ctx))); // R10

endmodule

bind pdu_reassembler pdu_reasm_chk #(.NCTX(NCTX), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .in_last    (in_last),
    .in_kind    (in_kind),
    .in_ctx     (in_ctx),
    .in_data    (in_data),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .done_valid (done_valid),
    .done_ctx   (done_ctx),
    .done_len   (done_len),
    .err_valid  (err_valid),
    .err_code   (err_code),
    .err_ctx    (err_ctx)
);

// File: tb/pdu_reassembler_test.sv
`timescale 1ns/1ps
module pdu_reassembler_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic [1:0]  in_kind = 2'd0;
    logic [1:0]  in_ctx = 2'd0;
    logic [7:0]  in_class = 8'd0;
    logic [15:0] in_stream = 16'd0;
    logic [31:0] in_data = 32'd0;
    logic [2:0]  in_bytes = 3'd0;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        done_valid;
    logic [1:0]  done_ctx;
    logic [16:0] done_len;
    logic [7:0]  done_class;
    logic [15:0] done_stream;
    logic        err_valid;
    logic [1:0]  err_code;
    logic [1:0]  err_ctx;

    always #2.5 clk = ~clk;

    pdu_reassembler uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_kind(in_kind), .in_ctx(in_ctx), .in_class(in_class), .in_stream(in_stream),
        .in_data(in_data), .in_bytes(in_bytes), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done_valid(done_valid), .done_ctx(done_ctx), .done_len(done_len),
        .done_class(done_class), .done_stream(done_stream), .err_valid(err_valid),
        .err_code(err_code), .err_ctx(err_ctx)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    int sg_wr, sg_wrbad, sg_done, sg_err;
    int d_len, d_ctx, d_cls, d_strm, e_code, e_ctx;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_seg(input int kind, input int ctx, input int cls, input int strm,
                            input int nbytes, input int base);
        int nb;
        nb = (nbytes + 3) / 4;
        sg_wr = 0; sg_wrbad = 0; sg_done = 0; sg_err = 0;
        for (int i = 0; i < nb; i++) begin
            logic [31:0] word;
            logic [15:0] exp_addr;
            word     = 32'hA500_0000 ^ 32'(ctx * 65536 + base / 4 + i);
            exp_addr = 16'(ctx * 16384 + base / 4 + i);
            @(negedge clk);
            in_valid  = 1'b1;
            in_first  = (i == 0);
            in_last   = (i == nb - 1);
            in_kind   = 2'(kind);
            in_ctx    = 2'(ctx);
            in_class  = 8'(cls);
            in_stream = 16'(strm);
            in_data   = word;
            in_bytes  = (i == nb - 1) ? 3'(nbytes - 4 * i) : 3'd4;
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            if (wr_en) begin
                sg_wr++;
                if (wr_addr != exp_addr || wr_data != word) sg_wrbad++;
            end
            if (done_valid) begin
                sg_done++;
                d_len = int'(done_len); d_ctx = int'(done_ctx);
                d_cls = int'(done_class); d_strm = int'(done_stream);
            end
            if (err_valid) begin
                sg_err++;
                e_code = int'(err_code); e_ctx = int'(err_ctx);
            end
        end
    endtask

    task automatic expect_err(input string req, input int code, input int ctx);
        chk(sg_err == 1, req, "error count", sg_err, 1);
        chk(e_code == code, req, "error code", e_code, code);
        chk(e_ctx == ctx, "R10", "error context", e_ctx, ctx);
    endtask

    task automatic expect_done(input string req, input int len, input int ctx, input int cls, input int strm);
        chk(sg_done == 1, req, "completion count", sg_done, 1);
        chk(d_len == len, req, "completion length", d_len, len);
        chk(d_ctx == ctx, req, "completion context", d_ctx, ctx);
        chk(d_cls == cls, req, "completion class", d_cls, cls);
        chk(d_strm == strm, req, "completion stream", d_strm, strm);
    endtask

    // fill a context with exactly 65536 bytes: start + 255 continuations of 256 bytes
    task automatic fill_max(input int ctx, input int cls, input int strm);
        send_seg(1, ctx, cls, strm, 256, 0);
        for (int s = 1; s < 256; s++) send_seg(2, ctx, cls, strm, 256, s * 256);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int explen [4];
        int order [4];
        int wrsum;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk(!wr_en && !done_valid && !err_valid, "R1", "outputs after reset",
            {wr_en, done_valid, err_valid}, 0);
        send_seg(2, 0, 1, 1, 8, 0);
        chk(sg_err == 1 && e_code == 0, "R1", "continuation after reset", e_code, 0);
        chk(sg_wr == 0, "R1", "writes after reset continuation", sg_wr, 0);

        // sweep: every context, every kind, from idle and from open PDU
        for (int c = 0; c < 4; c++) begin
            for (int act = 0; act < 2; act++) begin
                for (int k = 0; k < 4; k++) begin
                    int cls, strm, nbt, base, expwr;
                    cls  = 16 + c * 4 + k;
                    strm = 256 * c + 16 * act + k;
                    nbt  = 4 * k + 3;
                    if (act == 1) send_seg(1, c, cls, strm, 8, 0);
                    base = (act == 1 && k >= 2) ? 8 : 0;
                    send_seg(k, c, cls, strm, nbt, base);
                    if (act == 0 && k >= 2) expect_err("R6", 0, c);
                    else if (act == 1 && k <= 1) expect_err("R7", 1, c);
                    else chk(sg_err == 0, "R2", "no error", sg_err, 0);
                    if (k == 0) expect_done("R3", nbt, c, cls, strm);
                    else if (act == 1 && k == 3) expect_done("R2", 8 + nbt, c, cls, strm);
                    else chk(sg_done == 0, "R2", "no completion", sg_done, 0);
                    expwr = (act == 0 && k >= 2) ? 0 : (nbt + 3) / 4;
                    chk(sg_wr == expwr, (expwr == 0) ? "R6" : "R5", "write count", sg_wr, expwr);
                    chk(sg_wrbad == 0, "R5", "write address/data", sg_wrbad, 0);
                    if (k == 1 || (act == 1 && k == 2)) begin
                        int open_len;
                        open_len = (k == 1) ? nbt : 8 + nbt;
                        send_seg(3, c, cls, strm, 4, open_len);
                        expect_done((k == 1) ? "R7" : "R2", open_len + 4, c, cls, strm);
                        chk(sg_wrbad == 0, "R5", "end write address", sg_wrbad, 0);
                    end
                end
            end
        end

        // partial final beats
        for (int n = 1; n <= 9; n++) begin
            send_seg(0, 1, 200, 4000 + n, n, 0);
            expect_done("R3", n, 1, 200, 4000 + n);
            chk(sg_wr == (n + 3) / 4, "R2", "beats written", sg_wr, (n + 3) / 4);
        end

        // interleaved contexts
        for (int c = 0; c < 4; c++) begin
            send_seg(1, c, 64 + c, 8192 + 7 * c, 4 * (c + 1), 0);
            explen[c] = 4 * (c + 1);
        end
        for (int r = 0; r < 3; r++) begin
            for (int c = 3; c >= 0; c--) begin
                int nb2;
                nb2 = 8 + 4 * ((c + r) % 3);
                send_seg(2, c, 64 + c, 8192 + 7 * c, nb2, explen[c]);
                chk(sg_err == 0 && sg_wrbad == 0, "R4", "interleaved continuation", sg_err + sg_wrbad, 0);
                explen[c] += nb2;
            end
        end
        order = '{2, 0, 3, 1};
        foreach (order[j]) begin
            int c;
            c = order[j];
            send_seg(3, c, 64 + c, 8192 + 7 * c, 5, explen[c]);
            expect_done("R4", explen[c] + 5, c, 64 + c, 8192 + 7 * c);
        end

        // class mismatch and stream mismatch
        send_seg(1, 3, 10, 500, 8, 0);
        send_seg(3, 3, 11, 500, 8, 8);
        expect_err("R9", 3, 3);
        chk(sg_done == 0 && sg_wr == 0, "R9", "mismatch output", sg_done + sg_wr, 0);
        send_seg(2, 3, 10, 500, 4, 0);
        expect_err("R9", 0, 3);
        send_seg(1, 2, 10, 500, 8, 0);
        send_seg(3, 2, 10, 501, 8, 8);
        expect_err("R9", 3, 2);
        chk(sg_done == 0, "R9", "stream mismatch completion", sg_done, 0);

        // exactly 64 KB accepted
        wrsum = 0;
        send_seg(1, 0, 77, 1234, 256, 0);
        wrsum += sg_wr;
        for (int s = 1; s < 255; s++) begin
            send_seg(2, 0, 77, 1234, 256, s * 256);
            wrsum += sg_wr;
            if (sg_wrbad != 0) chk(1'b0, "R5", "large PDU address", sg_wrbad, 0);
        end
        send_seg(3, 0, 77, 1234, 256, 255 * 256);
        wrsum += sg_wr;
        expect_done("R8", 65536, 0, 77, 1234);
        chk(wrsum == 16384, "R8", "words written at limit", wrsum, 16384);

        // overflow inside a continuation segment
        fill_max(1, 88, 99);
        send_seg(2, 1, 88, 99, 4, 0);
        expect_err("R8", 2, 1);
        chk(sg_wr == 0, "R8", "overflow beat written", sg_wr, 0);
        send_seg(2, 1, 88, 99, 8, 0);
        chk(sg_err == 0 && sg_wr == 0, "R8", "discarded continuation", sg_err + sg_wr, 0);
        send_seg(3, 1, 88, 99, 4, 0);
        chk(sg_err == 0 && sg_done == 0 && sg_wr == 0, "R8", "end of discarded PDU",
            sg_err + sg_done + sg_wr, 0);
        send_seg(2, 1, 88, 99, 4, 0);
        expect_err("R8", 0, 1);

        // overflow inside an end segment
        fill_max(2, 5, 6);
        send_seg(3, 2, 5, 6, 8, 0);
        expect_err("R8", 2, 2);
        chk(sg_done == 0 && sg_wr == 0, "R8", "end overflow output", sg_done + sg_wr, 0);
        send_seg(2, 2, 5, 6, 4, 0);
        expect_err("R8", 0, 2);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule